// File: doc/BRIEF.md
# Digital Potentiometer Register Bank

This block keeps the register state behind two digitally set potentiometers and their two comparators. Each channel has a volatile wiper register holding a 6-bit tap position and a volatile comparator control register. Each of these four volatile targets is backed by four stored data registers, which are flops that stand in for nonvolatile cells. A serial front end decodes bus transactions into single-cycle commands. The bank executes them: direct reads and writes of the volatile targets and of the stored registers, single transfers between one target and one of its stored registers in either direction, and global transfers that act on all four targets at once.

Writes into stored registers model a long programming time. When such a write is committed, a busy flag rises and stays high for a parameterised number of cycles. The bank ignores every command while the flag is high, so the front end can withhold its acknowledge. A write-protect input, active low, blocks all stored-register writes. A soft reset reloads every volatile target from its stored register 0 and keeps the stored contents. A power-on reset puts factory defaults into the stored registers.

Top module: `potRegBank`

## Requirements
- R1: Command opcodes are 0 read volatile, 1 write volatile, 2 read stored, 3 write stored, 4 load stored→volatile, 5 save volatile→stored, 6 load all, 7 save all. Target code 0 selects wiper 0, 1 wiper 1, 2 control 0 and 3 control 1. A volatile write keeps data bits 5:0 and ignores bits 7:6.
- R2: A write stored command (3) places data bits 5:0 into stored register `cmdReg` of the addressed target. A read stored command (2) returns that value.
- R3: A load command (4) copies stored register `cmdReg` of the addressed target into that target's volatile register. No other target changes.
- R4: A save command (5) copies the addressed volatile register into its stored register `cmdReg`.
- R5: A load-all command (6) copies stored register `cmdReg` of every target into that target's volatile register in one cycle.
- R6: A save-all command (7) copies every volatile register into its own stored register `cmdReg` in one cycle.
- R7: An accepted stored-register write (opcodes 3, 5, 7) raises `busy` after the accepting edge, and `busy` stays high for exactly BUSY_CYCLES cycles. Any command that arrives while `busy` is high is ignored and produces no read data.
- R8: While `wpN` is low, opcodes 3, 5 and 7 change no stored register and do not raise `busy`. Volatile writes and loads still take effect.
- R9: The power-on reset `porN` loads stored register 0 with INIT_WIPER for the wiper targets and with INIT_CTRL for the control targets. All other stored registers are cleared, and every volatile register is loaded from its stored register 0. The soft reset `rstN` reloads every volatile register from its stored register 0 and keeps all stored registers.
- R10: `wiperPos[6c+5:6c]` is the wiper register of channel c. In control register c, bit 0 drives `cmpPower[c]` (1 = comparator powered), bit 1 drives `cmpOutEn[c]` and bit 2 drives `cmpHold[c]`. Bits 5:3 are user storage only.
- R11: The cycle after an accepted read, `rdValid` is high for one cycle and `rdData` carries 2'b00 followed by the six register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Synchronous power-on reset, active low |
| rstN | input | 1 | Synchronous soft reset (recall), active low |
| wpN | input | 1 | Write protect for stored registers, active low |
| cmdValid | input | 1 | Single-cycle command strobe from the front end |
| cmdOp | input | 3 | Command opcode |
| cmdTarget | input | 2 | Target select |
| cmdReg | input | 2 | Stored register select |
| cmdData | input | 8 | Write data byte |
| busy | output | 1 | Stored-register write in progress |
| rdValid | output | 1 | Read data valid |
| rdData | output | 8 | Read data byte |
| wiperPos | output | 12 | Tap positions, channel 0 in the low bits |
| cmpPower | output | 2 | Comparator power per channel |
| cmpOutEn | output | 2 | Comparator output enable per channel |
| cmpHold | output | 2 | Comparator output hold per channel |

## Verification
The assertions assume the front end presents each command as one strobe cycle. They also assume `cmdOp`, `cmdTarget`, `cmdReg` and `cmdData` stay steady during that cycle, that `wpN` changes only between commands, and that no command overlaps a reset. The stimulus drives every input just after a falling edge and holds it for one full cycle. It changes `wpN` and the resets only when no command is active. It also issues commands on purpose while `busy` is high, so the rule that such commands are ignored is actually exercised.

// File: rtl/potbank_pkg.sv
package potbank_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    OP_RD_VOL   = 3'd0,
    OP_WR_VOL   = 3'd1,
    OP_RD_DR    = 3'd2,
    OP_WR_DR    = 3'd3,
    OP_LOAD     = 3'd4,
    OP_SAVE     = 3'd5,
    OP_LOAD_ALL = 3'd6,
    OP_SAVE_ALL = 3'd7
  } bankOp_t;

  typedef struct packed {
    logic rdVol;
    logic rdDr;
    logic wrVol;
    logic wrDr;
    logic toVol;
    logic toDr;
    logic allTgt;
  } bankStrobe_t;
endpackage

// File: rtl/potbank_ctrl.sv
module potbank_ctrl
  import potbank_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        rstN,
  input  logic        wpN,
  input  logic        cmdValid,
  input  bankOp_t     cmdOp,
  output bankStrobe_t stb,
  output logic        busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic accept, nvOp, allowed, nvCommit;

  assign accept   = cmdValid && !busy;
  assign nvOp     = (cmdOp == OP_WR_DR) || (cmdOp == OP_SAVE) || (cmdOp == OP_SAVE_ALL);
  assign allowed  = accept && (!nvOp || wpN);
  assign nvCommit = allowed && nvOp;

  always_comb begin
    stb = '0;
    if (allowed) begin
      case (cmdOp)
        OP_RD_VOL:   stb.rdVol = 1'b1;
        OP_WR_VOL:   stb.wrVol = 1'b1;
        OP_RD_DR:    stb.rdDr  = 1'b1;
        OP_WR_DR:    stb.wrDr  = 1'b1;
        OP_LOAD:     stb.toVol = 1'b1;
        OP_SAVE:     stb.toDr  = 1'b1;
        OP_LOAD_ALL: begin stb.toVol = 1'b1; stb.allTgt = 1'b1; end
        OP_SAVE_ALL: begin stb.toDr  = 1'b1; stb.allTgt = 1'b1; end
        default:     stb = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!porN || !rstN)       busyCnt <= '0;
    else if (nvCommit)        busyCnt <= CNT_W'(BUSY_CYCLES);
    else if (busyCnt != '0)   busyCnt <= busyCnt - 1'b1;
  end

  assign busy = (busyCnt != '0);

  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $rose(busy) |-> $past(nvCommit));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (busy && busyCnt != CNT_W'(1) && !nvCommit) |=> busy);

  assert_wp_block_R8: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (cmdValid && !busy && !wpN && nvOp) |=> !busy);
endmodule

// File: rtl/potbank_dp.sv
module potbank_dp
  import potbank_pkg::*;
#(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned TAP_BITS   = 6,
  parameter int unsigned NUM_DR     = 4,
  parameter int unsigned INIT_WIPER = 32,
  parameter int unsigned INIT_CTRL  = 3
) (
  input  logic                            clk,
  input  logic                            porN,
  input  logic                            rstN,
  input  bankStrobe_t                     stb,
  input  logic [$clog2(2*NUM_CH)-1:0]     tgt,
  input  logic [$clog2(NUM_DR)-1:0]       rsel,
  input  logic [TAP_BITS-1:0]             wdata,
  output logic                            rdValid,
  output logic [DATA_W-1:0]               rdData,
  output logic [2*NUM_CH*TAP_BITS-1:0]    volFlat
);
  localparam int NUM_TGT = 2 * NUM_CH;
  localparam int TGT_W   = $clog2(NUM_TGT);
  localparam int DR_W    = $clog2(NUM_DR);

  logic [TAP_BITS-1:0] vol [NUM_TGT];
  logic [TAP_BITS-1:0] dr  [NUM_TGT][NUM_DR];
  logic [NUM_TGT*NUM_DR*TAP_BITS-1:0] drFlat;

  for (genvar t = 0; t < NUM_TGT; t++) begin : gTgt
    localparam logic [TAP_BITS-1:0] INIT_VAL =
      (t < NUM_CH) ? TAP_BITS'(INIT_WIPER) : TAP_BITS'(INIT_CTRL);
    logic hitTgt;
    assign hitTgt = (tgt == TGT_W'(t));

    always_ff @(posedge clk) begin
      if (!porN)                                vol[t] <= INIT_VAL;
      else if (!rstN)                           vol[t] <= dr[t][0];
      else if (stb.wrVol && hitTgt)             vol[t] <= wdata;
      else if (stb.toVol && (stb.allTgt || hitTgt)) vol[t] <= dr[t][rsel];
    end

    assign volFlat[t*TAP_BITS +: TAP_BITS] = vol[t];

    for (genvar r = 0; r < NUM_DR; r++) begin : gReg
      logic hitReg;
      assign hitReg = (rsel == DR_W'(r));

      always_ff @(posedge clk) begin
        if (!porN)                                          dr[t][r] <= (r == 0) ? INIT_VAL : '0;
        else if (!rstN)                                     dr[t][r] <= dr[t][r];
        else if (stb.wrDr && hitTgt && hitReg)              dr[t][r] <= wdata;
        else if (stb.toDr && (stb.allTgt || hitTgt) && hitReg) dr[t][r] <= vol[t];
      end

      assign drFlat[(t*NUM_DR+r)*TAP_BITS +: TAP_BITS] = dr[t][r];
    end
  end

  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdVol || stb.rdDr;
      if (stb.rdVol)     rdData <= {{(DATA_W-TAP_BITS){1'b0}}, vol[tgt]};
      else if (stb.rdDr) rdData <= {{(DATA_W-TAP_BITS){1'b0}}, dr[tgt][rsel]};
    end
  end

  assert_keep_vol_R3: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (!stb.wrVol && !stb.toVol) |=> $stable(volFlat));

  assert_keep_dr_R8: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (!stb.wrDr && !stb.toDr) |=> $stable(drFlat));

  assert_rd_pad_R11: assert property (@(posedge clk) disable iff (!porN || !rstN)
    rdValid |-> (rdData[DATA_W-1:TAP_BITS] == '0));
endmodule

// File: rtl/potRegBank.sv
module potRegBank
  import potbank_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned TAP_BITS    = 6,
  parameter int unsigned NUM_DR      = 4,
  parameter int unsigned BUSY_CYCLES = 1000,
  parameter int unsigned INIT_WIPER  = 32,
  parameter int unsigned INIT_CTRL   = 3
) (
  input  logic                          clk,
  input  logic                          porN,
  input  logic                          rstN,
  input  logic                          wpN,
  input  logic                          cmdValid,
  input  logic [2:0]                    cmdOp,
  input  logic [$clog2(2*NUM_CH)-1:0]   cmdTarget,
  input  logic [$clog2(NUM_DR)-1:0]     cmdReg,
  input  logic [7:0]                    cmdData,
  output logic                          busy,
  output logic                          rdValid,
  output logic [7:0]                    rdData,
  output logic [NUM_CH*TAP_BITS-1:0]    wiperPos,
  output logic [NUM_CH-1:0]             cmpPower,
  output logic [NUM_CH-1:0]             cmpOutEn,
  output logic [NUM_CH-1:0]             cmpHold
);
  bankStrobe_t stb;
  logic [2*NUM_CH*TAP_BITS-1:0] volFlat;
  logic unusedHigh;

  assign unusedHigh = ^cmdData[7:TAP_BITS];

  potbank_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .porN(porN), .rstN(rstN), .wpN(wpN),
    .cmdValid(cmdValid), .cmdOp(bankOp_t'(cmdOp)),
    .stb(stb), .busy(busy)
  );

  potbank_dp #(
    .NUM_CH(NUM_CH), .TAP_BITS(TAP_BITS), .NUM_DR(NUM_DR),
    .INIT_WIPER(INIT_WIPER), .INIT_CTRL(INIT_CTRL)
  ) u_dp (
    .clk(clk), .porN(porN), .rstN(rstN), .stb(stb),
    .tgt(cmdTarget), .rsel(cmdReg), .wdata(cmdData[TAP_BITS-1:0]),
    .rdValid(rdValid), .rdData(rdData), .volFlat(volFlat)
  );

  assign wiperPos = volFlat[NUM_CH*TAP_BITS-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : gCmp
    localparam int BASE = (NUM_CH + c) * TAP_BITS;
    assign cmpPower[c] = volFlat[BASE + 0];
    assign cmpOutEn[c] = volFlat[BASE + 1];
    assign cmpHold[c]  = volFlat[BASE + 2];
  end

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (cmdValid && busy) |=> ($stable(volFlat) && !rdValid));
endmodule

// File: tb/potRegBank_bench.sv
`timescale 1ns/100ps
module potRegBank_bench;
  localparam int BUSY = 20;
  localparam int INIT_W = 32;
  localparam int INIT_C = 3;

  logic clk = 1'b0;
  logic porN, rstN, wpN, cmdValid;
  logic [2:0] cmdOp;
  logic [1:0] cmdTarget, cmdReg;
  logic [7:0] cmdData;
  logic busy, rdValid;
  logic [7:0] rdData;
  logic [11:0] wiperPos;
  logic [1:0] cmpPower, cmpOutEn, cmpHold;

  always #2.5 clk = ~clk;

  potRegBank #(.BUSY_CYCLES(BUSY), .INIT_WIPER(INIT_W), .INIT_CTRL(INIT_C)) u_potRegBank (
    .clk(clk), .porN(porN), .rstN(rstN), .wpN(wpN), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdTarget(cmdTarget), .cmdReg(cmdReg), .cmdData(cmdData),
    .busy(busy), .rdValid(rdValid), .rdData(rdData), .wiperPos(wiperPos),
    .cmpPower(cmpPower), .cmpOutEn(cmpOutEn), .cmpHold(cmpHold)
  );

  int checks = 0, fails = 0, mBusy = 0;
  bit done = 0;
  logic [5:0] mVol [4];
  logic [5:0] mDr  [4][4];
  logic [7:0] expQ [$];
  string reqQ [$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (mBusy > 0) mBusy--;
    @(negedge clk);
  endtask

  task automatic modelPor();
    for (int t = 0; t < 4; t++) begin
      for (int r = 0; r < 4; r++) mDr[t][r] = (r == 0) ? ((t < 2) ? 6'(INIT_W) : 6'(INIT_C)) : 6'd0;
      mVol[t] = mDr[t][0];
    end
    mBusy = 0;
  endtask

  task automatic checkOuts(input string req);
    chk(req, "wiper0", int'(wiperPos[5:0]), int'(mVol[0]));
    chk(req, "wiper1", int'(wiperPos[11:6]), int'(mVol[1]));
    chk(req, "power", int'(cmpPower), int'({mVol[3][0], mVol[2][0]}));
    chk(req, "outEn", int'(cmpOutEn), int'({mVol[3][1], mVol[2][1]}));
    chk(req, "hold", int'(cmpHold), int'({mVol[3][2], mVol[2][2]}));
    chk(req, "busy", int'(busy), int'(mBusy != 0));
  endtask

  task automatic issue(input int op, input int t, input int r, input logic [7:0] d, input string req);
    bit ok, nv;
    nv = (op == 3 || op == 5 || op == 7);
    ok = (mBusy == 0) && (!nv || wpN);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdTarget = 2'(t); cmdReg = 2'(r); cmdData = d;
    if (ok) begin
      case (op)
        0: begin expQ.push_back({2'b00, mVol[t]}); reqQ.push_back(req); end
        1: mVol[t] = d[5:0];
        2: begin expQ.push_back({2'b00, mDr[t][r]}); reqQ.push_back(req); end
        3: mDr[t][r] = d[5:0];
        4: mVol[t] = mDr[t][r];
        5: mDr[t][r] = mVol[t];
        6: for (int k = 0; k < 4; k++) mVol[k] = mDr[k][r];
        default: for (int k = 0; k < 4; k++) mDr[k][r] = mVol[k];
      endcase
    end
    tick();
    cmdValid = 1'b0;
    if (ok && nv) mBusy = BUSY;
  endtask

  task automatic waitIdle();
    while (mBusy > 0) tick();
    tick();
  endtask

  always @(negedge clk) begin
    if (porN && rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 unexpected read data: actual %0h expected none", rdData);
      end else begin
        logic [7:0] e;
        string rq;
        e = expQ.pop_front();
        rq = reqQ.pop_front();
        chk(rq, "rdData", int'(rdData), int'(e));
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    porN = 0; rstN = 0; wpN = 1; cmdValid = 0; cmdOp = 0; cmdTarget = 0; cmdReg = 0; cmdData = 0;
    modelPor();
    repeat (3) tick();
    porN = 1; rstN = 1;
    tick();
    checkOuts("R9");
    chk("R10", "power after reset", int'(cmpPower), 3);

    // R1: volatile write with upper bits ignored, then read back
    issue(1, 0, 0, 8'hC5, "R1");
    checkOuts("R1");
    issue(0, 0, 0, 8'h00, "R1");
    issue(1, 3, 0, 8'h06, "R10");
    checkOuts("R10");
    chk("R10", "hold ch1", int'(cmpHold[1]), 1);
    issue(0, 3, 0, 8'h00, "R11");

    // R2 and R7: stored write raises busy; commands ignored while busy
    issue(3, 1, 2, 8'hEA, "R2");
    checkOuts("R7");
    chk("R7", "busy raised", int'(busy), 1);
    issue(0, 0, 0, 8'h00, "R7");
    issue(1, 0, 0, 8'h09, "R7");
    checkOuts("R7");
    waitIdle();
    chk("R7", "busy cleared", int'(busy), 0);
    issue(2, 1, 2, 8'h00, "R2");

    // R3: single load
    issue(4, 1, 2, 8'h00, "R3");
    checkOuts("R3");

    // R4: single save
    issue(5, 0, 3, 8'h00, "R4");
    waitIdle();
    issue(2, 0, 3, 8'h00, "R4");

    // R6: save all
    issue(7, 0, 1, 8'h00, "R6");
    waitIdle();
    for (int t = 0; t < 4; t++) issue(2, t, 1, 8'h00, "R6");

    // R5: load all from register 0
    issue(5'd6, 0, 0, 8'h00, "R5");
    checkOuts("R5");

    // R8: write protect
    wpN = 0;
    issue(3, 0, 1, 8'h07, "R8");
    chk("R8", "busy under wp", int'(busy), 0);
    issue(7, 0, 2, 8'h00, "R8");
    issue(2, 0, 1, 8'h00, "R8");
    issue(2, 0, 2, 8'h00, "R8");
    issue(1, 0, 0, 8'h11, "R8");
    checkOuts("R8");
    wpN = 1;
    tick();

    // R9: soft reset recall keeps stored contents
    issue(3, 0, 0, 8'h15, "R9");
    waitIdle();
    issue(1, 0, 0, 8'h02, "R9");
    issue(1, 2, 0, 8'h3C, "R9");
    rstN = 0;
    tick();
    rstN = 1;
    for (int t = 0; t < 4; t++) mVol[t] = mDr[t][0];
    mBusy = 0;
    tick();
    checkOuts("R9");
    issue(2, 1, 2, 8'h00, "R9");
    tick(); tick();
    chk("R11", "pending reads", expQ.size(), 0);
    finishRun();
  end
endmodule